// File: doc/BRIEF.md
# Two-Sector Single-Word Nonvolatile Store Controller

This block keeps one 32-bit value in word-programmable flash as if it were an EEPROM cell. Two flash sectors take turns. A sector holds an array of data slots, a field of status bits and a signature word. New values are never written over old ones. Each new value goes into the next free slot, and one more status bit is then cleared. After a reset the block finds the current value by counting the cleared status bits. It does not look at the data itself, so an all-ones value still counts as stored.

A client pulses one of three requests: initialise, read or write. It then waits for a one-cycle completion strobe that carries a 2-bit result code. When the active sector is full, the next write moves to the other sector. The copy, the new value, the status update and the signature all go there first. The old sector is erased last, so a reset at any point leaves the last value recoverable. At power-up the block scans both sectors before it serves any request. If both sectors carry the signature, it first finishes erasing the one with fewer cleared status bits.

The flash port issues one operation at a time: read, program or erase. A program can only turn ones into zeros. Each sector has its own capacity parameter.

Top module: `ssn_store`

## Requirements
- R1: From reset, `busy` is high while the controller reads both signatures and every status word. Requests raised while `busy` is high produce no `done`.
- R2: The initialise request performs three flash operations in order: erase sector 0, erase sector 1, then program 0x0000600D into the signature word of sector 0. A read afterwards returns code 1.
- R3: A write into a sector with free slots makes two programs. First the value goes into data slot `count`. Then status word `count/32` is programmed with only bit `count%32` cleared. The write returns code 0. Flash commands are 1 = read, 2 = program, 3 = erase.
- R4: A read with `count` > 0 reads data slot `count-1` and returns that word on `rd_data` with code 0. An all-ones value is returned as valid.
- R5: A read with no cleared status bit returns code 1 and leaves `rd_data` unchanged.
- R6: When neither sector holds the signature, read and write both return code 2 and issue no flash operation.
- R7: A write into a full sector issues, in this order: a read of the last slot, a program of that value into slot 0 of the other sector, a program of the new value into slot 1, a program of status word 0 with bits 0 and 1 cleared, a program of the signature, and an erase of the old sector. Later reads come from the other sector.
- R8: Each sector's capacity is a separate parameter from 1 to 1984. A sector switch happens exactly when that sector's own capacity is used up.
- R9: If both sectors carry the signature at power-up, the sector with fewer cleared status bits is erased (sector 1 on a tie), and requests are then served from the other sector.
- R10: Every accepted request ends with `done` high for exactly one cycle. The result code is 0 (success), 1 (no valid data) or 2 (full erase required). When requests arrive together, initialise wins over write, and write wins over read.
- R11: The status field continues past 32 bits. The 33rd data-set clears bit 0 of status word 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Pulse: erase both sectors and validate sector 0 |
| rd_req | input | 1 | Pulse: read the current value |
| wr_req | input | 1 | Pulse: store `wr_data` |
| wr_data | input | 32 | Value to store |
| busy | output | 1 | Controller not idle; requests ignored |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | Result code, valid with `done` |
| rd_data | output | 32 | Last value read |
| fl_req | output | 1 | One-cycle flash operation strobe |
| fl_cmd | output | 2 | 1 read, 2 program, 3 erase |
| fl_addr | output | FAW | Word address; top bit selects the sector |
| fl_wdata | output | 32 | Program data (ANDed into the word) |
| fl_ack | input | 1 | Flash operation finished |
| fl_rdata | input | 32 | Read data, valid with `fl_ack` |

## Verification
A miscounted status field shows up at the ports on the next operation. The following write programs a wrong slot or clears a wrong status bit, and the following read fetches the wrong slot, so the error is visible within one request. A wrong active-sector choice or a wrong swap order appears in the flash command trace and in the flash contents during the very swap that causes it. A wrong power-up decision shows up as an erase aimed at the wrong sector before `busy` falls.

// File: rtl/ssn_pkg.sv
package ssn_pkg;
   typedef enum logic [1:0] {FL_NOP = 2'd0, FL_READ = 2'd1, FL_PROG = 2'd2, FL_ERASE = 2'd3} fl_cmd_e;
   typedef enum logic [1:0] {RES_OK = 2'd0, RES_EMPTY = 2'd1, RES_NEEDS_INIT = 2'd2} res_e;
   typedef enum logic [1:0] {SLOT_DATA, SLOT_STAT, SLOT_SIG} slot_e;
   localparam logic [31:0] SIG_GOOD = 32'h0000_600D;
   localparam int MAX_SETS = 1984;
   function automatic int stat_words(input int n);
      return (n + 31) / 32;
   endfunction
endpackage

// File: rtl/ssn_zero_count.sv
module ssn_zero_count #(
   parameter int W    = 32,
   parameter int CNTW = 6
) (
   input  logic [W-1:0]    word,
   input  logic [CNTW-1:0] nvalid,
   output logic [CNTW-1:0] zeros
);
   logic [W-1:0] hit;
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign hit[b] = ~word[b] && (CNTW'(b) < nvalid);
   end
   assign zeros = CNTW'($countones(hit));
endmodule

// File: rtl/ssn_addr_map.sv
module ssn_addr_map import ssn_pkg::*; #(
   parameter int SETS0 = 8,
   parameter int SETS1 = 8,
   parameter int SAW   = 4,
   parameter int CW    = 4
) (
   input  logic          sec,
   input  slot_e         kind,
   input  logic [CW-1:0] idx,
   output logic [SAW:0]  addr
);
   logic [SAW-1:0] stat_base [2];
   logic [SAW-1:0] sig_off   [2];
   for (genvar s = 0; s < 2; s++) begin : g_sec
      localparam int NS = (s == 0) ? SETS0 : SETS1;
      assign stat_base[s] = SAW'(NS);
      assign sig_off[s]   = SAW'(NS + stat_words(NS));
   end
   always_comb begin
      unique case (kind)
         SLOT_STAT: addr = {sec, stat_base[sec] + SAW'(idx)};
         SLOT_SIG:  addr = {sec, sig_off[sec]};
         default:   addr = {sec, SAW'(idx)};
      endcase
   end
endmodule

// File: rtl/ssn_store.sv
module ssn_store import ssn_pkg::*; #(
   parameter int SETS0 = 8,
   parameter int SETS1 = 8,
   localparam int STW0 = stat_words(SETS0),
   localparam int STW1 = stat_words(SETS1),
   localparam int REGM = (SETS0 + STW0 > SETS1 + STW1) ? SETS0 + STW0 + 1 : SETS1 + STW1 + 1,
   localparam int SAW  = $clog2(REGM),
   localparam int FAW  = SAW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           init_req,
   input  logic           rd_req,
   input  logic           wr_req,
   input  logic [31:0]    wr_data,
   output logic           busy,
   output logic           done,
   output logic [1:0]     result,
   output logic [31:0]    rd_data,
   output logic           fl_req,
   output logic [1:0]     fl_cmd,
   output logic [FAW-1:0] fl_addr,
   output logic [31:0]    fl_wdata,
   input  logic           fl_ack,
   input  logic [31:0]    fl_rdata
);
   localparam int MAXS = (SETS0 > SETS1) ? SETS0 : SETS1;
   localparam int CW   = $clog2(MAXS + 1);
   localparam logic [CW-1:0] CAP0 = CW'(SETS0);
   localparam logic [CW-1:0] CAP1 = CW'(SETS1);

   if (SETS0 < 1 || SETS0 > MAX_SETS) begin : g_bad_cap0
      $error("SETS0 out of range");
   end
   if (SETS1 < 1 || SETS1 > MAX_SETS) begin : g_bad_cap1
      $error("SETS1 out of range");
   end

   typedef enum logic [4:0] {
      S_SIG0, S_SIG1, S_SCAN, S_DECIDE, S_BOOT_ER, S_IDLE, S_RD, S_WR_DATA, S_WR_STAT,
      S_SW_READ, S_SW_COPY, S_SW_NEW, S_SW_STAT, S_SW_SIG, S_SW_ERASE,
      S_IN_ER0, S_IN_ER1, S_IN_SIG
   } state_e;

   state_e        state;
   logic          pend, act, vld, scan_s, victim;
   logic [1:0]    sig_ok;
   logic [CW-1:0] cnt_q [2];
   logic [CW-1:0] scan_w;
   logic [31:0]   din_q, last_q;

   // Derived view of the active and spare sectors
   logic          oth, two_slot;
   logic [CW-1:0] cap_act, cap_oth, cnt_act, scan_cap, scan_last;
   logic [31:0]   cnt_w, rem;
   logic [5:0]    nvalid, zeros;
   assign oth       = ~act;
   assign cap_act   = act ? CAP1 : CAP0;
   assign cap_oth   = act ? CAP0 : CAP1;
   assign two_slot  = cap_oth >= CW'(2);
   assign cnt_act   = cnt_q[act];
   assign cnt_w     = 32'(cnt_act);
   assign scan_cap  = scan_s ? CAP1 : CAP0;
   assign scan_last = scan_s ? CW'(STW1 - 1) : CW'(STW0 - 1);
   assign rem       = 32'(scan_cap) - (32'(scan_w) << 5);
   assign nvalid    = (rem > 32'd32) ? 6'd32 : rem[5:0];
   assign busy      = (state != S_IDLE);

   ssn_zero_count #(.W(32), .CNTW(6)) zc_i (.word(fl_rdata), .nvalid(nvalid), .zeros(zeros));

   // Flash operation chosen by the current state
   fl_cmd_e       op_cmd;
   logic          op_sec;
   slot_e         op_kind;
   logic [CW-1:0] op_idx;
   logic [31:0]   op_wd;
   logic [FAW-1:0] op_addr;

   always_comb begin
      op_cmd = FL_NOP; op_sec = act; op_kind = SLOT_DATA; op_idx = '0; op_wd = '1;
      unique case (state)
         S_SIG0:     begin op_cmd = FL_READ;  op_sec = 1'b0; op_kind = SLOT_SIG; end
         S_SIG1:     begin op_cmd = FL_READ;  op_sec = 1'b1; op_kind = SLOT_SIG; end
         S_SCAN:     begin op_cmd = FL_READ;  op_sec = scan_s; op_kind = SLOT_STAT; op_idx = scan_w; end
         S_BOOT_ER:  begin op_cmd = FL_ERASE; op_sec = victim; end
         S_RD:       begin op_cmd = FL_READ;  op_idx = cnt_act - CW'(1); end
         S_WR_DATA:  begin op_cmd = FL_PROG;  op_idx = cnt_act; op_wd = din_q; end
         S_WR_STAT:  begin
            op_cmd = FL_PROG; op_kind = SLOT_STAT; op_idx = CW'(cnt_w >> 5);
            op_wd = ~(32'h1 << cnt_w[4:0]);
         end
         S_SW_READ:  begin op_cmd = FL_READ;  op_idx = cap_act - CW'(1); end
         S_SW_COPY:  begin op_cmd = FL_PROG;  op_sec = oth; op_wd = last_q; end
         S_SW_NEW:   begin op_cmd = FL_PROG;  op_sec = oth; op_idx = CW'(two_slot); op_wd = din_q; end
         S_SW_STAT:  begin
            op_cmd = FL_PROG; op_sec = oth; op_kind = SLOT_STAT;
            op_wd = two_slot ? 32'hFFFF_FFFC : 32'hFFFF_FFFE;
         end
         S_SW_SIG:   begin op_cmd = FL_PROG;  op_sec = oth; op_kind = SLOT_SIG; op_wd = SIG_GOOD; end
         S_SW_ERASE: begin op_cmd = FL_ERASE; end
         S_IN_ER0:   begin op_cmd = FL_ERASE; op_sec = 1'b0; end
         S_IN_ER1:   begin op_cmd = FL_ERASE; op_sec = 1'b1; end
         S_IN_SIG:   begin op_cmd = FL_PROG;  op_sec = 1'b0; op_kind = SLOT_SIG; op_wd = SIG_GOOD; end
         default:    ;
      endcase
   end

   ssn_addr_map #(.SETS0(SETS0), .SETS1(SETS1), .SAW(SAW), .CW(CW)) map_i (
      .sec(op_sec), .kind(op_kind), .idx(op_idx), .addr(op_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_SIG0; pend <= 1'b0; act <= 1'b0; vld <= 1'b0; scan_s <= 1'b0;
         victim <= 1'b0; sig_ok <= 2'b00; cnt_q[0] <= '0; cnt_q[1] <= '0; scan_w <= '0;
         din_q <= '0; last_q <= '0; done <= 1'b0; result <= RES_OK; rd_data <= '0;
         fl_req <= 1'b0; fl_cmd <= FL_NOP; fl_addr <= '0; fl_wdata <= '0;
      end else begin
         fl_req <= 1'b0;
         done   <= 1'b0;
         if (state == S_IDLE) begin
            if (init_req) state <= S_IN_ER0;
            else if (wr_req) begin
               if (!vld) begin done <= 1'b1; result <= RES_NEEDS_INIT; end
               else begin
                  din_q <= wr_data;
                  state <= (cnt_act == cap_act) ? S_SW_READ : S_WR_DATA;
               end
            end else if (rd_req) begin
               if (!vld) begin done <= 1'b1; result <= RES_NEEDS_INIT; end
               else if (cnt_act == '0) begin done <= 1'b1; result <= RES_EMPTY; end
               else state <= S_RD;
            end
         end else if (state == S_DECIDE) begin
            unique case (sig_ok)
               2'b11: begin
                  victim <= (cnt_q[0] < cnt_q[1]) ? 1'b0 : 1'b1;
                  act    <= (cnt_q[0] < cnt_q[1]) ? 1'b1 : 1'b0;
                  vld    <= 1'b1;
                  state  <= S_BOOT_ER;
               end
               2'b01:   begin act <= 1'b0; vld <= 1'b1; cnt_q[1] <= '0; state <= S_IDLE; end
               2'b10:   begin act <= 1'b1; vld <= 1'b1; cnt_q[0] <= '0; state <= S_IDLE; end
               default: begin vld <= 1'b0; state <= S_IDLE; end
            endcase
         end else if (!pend) begin
            fl_req <= 1'b1; fl_cmd <= op_cmd; fl_addr <= op_addr; fl_wdata <= op_wd;
            pend   <= 1'b1;
         end else if (fl_ack) begin
            pend <= 1'b0;
            unique case (state)
               S_SIG0: begin sig_ok[0] <= (fl_rdata == SIG_GOOD); state <= S_SIG1; end
               S_SIG1: begin
                  sig_ok[1] <= (fl_rdata == SIG_GOOD);
                  scan_s <= 1'b0; scan_w <= '0; state <= S_SCAN;
               end
               S_SCAN: begin
                  cnt_q[scan_s] <= cnt_q[scan_s] + CW'(zeros);
                  if (scan_w != scan_last) scan_w <= scan_w + CW'(1);
                  else if (!scan_s) begin scan_s <= 1'b1; scan_w <= '0; end
                  else state <= S_DECIDE;
               end
               S_BOOT_ER: begin cnt_q[victim] <= '0; state <= S_IDLE; end
               S_RD: begin
                  rd_data <= fl_rdata; done <= 1'b1; result <= RES_OK; state <= S_IDLE;
               end
               S_WR_DATA: state <= S_WR_STAT;
               S_WR_STAT: begin
                  cnt_q[act] <= cnt_act + CW'(1);
                  done <= 1'b1; result <= RES_OK; state <= S_IDLE;
               end
               S_SW_READ: begin last_q <= fl_rdata; state <= two_slot ? S_SW_COPY : S_SW_NEW; end
               S_SW_COPY: state <= S_SW_NEW;
               S_SW_NEW:  state <= S_SW_STAT;
               S_SW_STAT: state <= S_SW_SIG;
               S_SW_SIG:  state <= S_SW_ERASE;
               S_SW_ERASE: begin
                  cnt_q[oth] <= two_slot ? CW'(2) : CW'(1);
                  cnt_q[act] <= '0; act <= oth;
                  done <= 1'b1; result <= RES_OK; state <= S_IDLE;
               end
               S_IN_ER0: state <= S_IN_ER1;
               S_IN_ER1: state <= S_IN_SIG;
               S_IN_SIG: begin
                  act <= 1'b0; vld <= 1'b1; cnt_q[0] <= '0; cnt_q[1] <= '0;
                  done <= 1'b1; result <= RES_OK; state <= S_IDLE;
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ssn_store_chk.sv
module ssn_store_chk import ssn_pkg::*; #(
   parameter int SETS0 = 8,
   parameter int SETS1 = 8,
   parameter int FAW   = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           busy,
   input logic           done,
   input logic [1:0]     result,
   input logic           fl_req,
   input logic [1:0]     fl_cmd,
   input logic [FAW-1:0] fl_addr,
   input logic [31:0]    fl_wdata,
   input logic           fl_ack
);
   localparam int SAW = FAW - 1;
   localparam logic [FAW-1:0] SIGA0 = FAW'(SETS0 + stat_words(SETS0));
   localparam logic [FAW-1:0] SIGA1 = FAW'((1 << SAW) + SETS1 + stat_words(SETS1));
   localparam logic [FAW-1:0] STLO0 = FAW'(SETS0);
   localparam logic [FAW-1:0] STLO1 = FAW'((1 << SAW) + SETS1);

   logic outstanding;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outstanding <= 1'b0;
      else if (fl_req) outstanding <= 1'b1;
      else if (fl_ack) outstanding <= 1'b0;
   end

   logic prog_sig, prog_stat;
   assign prog_sig  = fl_req && fl_cmd == 2'd2 && (fl_addr == SIGA0 || fl_addr == SIGA1);
   assign prog_stat = fl_req && fl_cmd == 2'd2 &&
                      ((fl_addr >= STLO0 && fl_addr < SIGA0) || (fl_addr >= STLO1 && fl_addr < SIGA1));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n) done |-> result != 2'd3);
   assert_one_op_R7:      assert property (@(posedge clk) disable iff (!rst_n) fl_req |-> !outstanding);
   assert_idle_quiet_R1:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !fl_req);
   assert_sig_value_R2:   assert property (@(posedge clk) disable iff (!rst_n) prog_sig |-> fl_wdata == SIG_GOOD);
   assert_stat_clear_R3:  assert property (@(posedge clk) disable iff (!rst_n)
                             prog_stat |-> ($countones(~fl_wdata) == 1 || $countones(~fl_wdata) == 2));
   assert_erase_base_R7:  assert property (@(posedge clk) disable iff (!rst_n)
                             (fl_req && fl_cmd == 2'd3) |-> fl_addr[SAW-1:0] == '0);
endmodule

bind ssn_store ssn_store_chk #(.SETS0(SETS0), .SETS1(SETS1), .FAW(FAW)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result), .fl_req(fl_req),
   .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack));

// File: tb/ssn_store_tb_top.sv
module ssn_store_tb_top;
   localparam int S0 = 34, S1 = 3, SAW = 6, FAW = 7, HALF = 4;
   localparam int B1 = 64;                    // sector 1 base
   localparam int ST0 = 34, SG0 = 36, ST1 = B1 + 3, SG1 = B1 + 4;

   logic clk = 0, rst_n = 0, init_req = 0, rd_req = 0, wr_req = 0;
   logic [31:0] wr_data = 0;
   logic busy, done, fl_req, fl_ack = 0;
   logic [1:0] result, fl_cmd;
   logic [31:0] rd_data, fl_wdata, fl_rdata = 0;
   logic [FAW-1:0] fl_addr;

   always #HALF clk = ~clk;

   ssn_store #(.SETS0(S0), .SETS1(S1)) dut_i (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .rd_req(rd_req), .wr_req(wr_req),
      .wr_data(wr_data), .busy(busy), .done(done), .result(result), .rd_data(rd_data),
      .fl_req(fl_req), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_ack(fl_ack), .fl_rdata(fl_rdata));

   // Flash model with operation trace
   logic [31:0] mem [128];
   logic [1:0]  q_cmd = 0;
   logic [FAW-1:0] q_addr = 0;
   logic [31:0] q_wd = 0;
   int lat = 0, tr_n = 0;
   logic [1:0]  tr_cmd [256];
   logic [FAW-1:0] tr_addr [256];
   logic [31:0] tr_wd [256];

   always @(posedge clk) begin
      fl_ack <= 1'b0;
      if (fl_req) begin
         q_cmd <= fl_cmd; q_addr <= fl_addr; q_wd <= fl_wdata; lat <= 2;
         if (tr_n < 256) begin
            tr_cmd[tr_n] <= fl_cmd; tr_addr[tr_n] <= fl_addr; tr_wd[tr_n] <= fl_wdata;
         end
         tr_n <= tr_n + 1;
      end else if (lat != 0) begin
         lat <= lat - 1;
         if (lat == 1) begin
            fl_ack <= 1'b1;
            if (q_cmd == 2'd1) fl_rdata <= mem[q_addr];
            else if (q_cmd == 2'd2) mem[q_addr] <= mem[q_addr] & q_wd;
            else if (q_cmd == 2'd3)
               for (int k = 0; k < 64; k++) mem[{q_addr[SAW], 6'(k)}] <= '1;
         end
      end
   end

   int n_chk = 0, n_err = 0;
   task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
      n_chk++;
      if (a !== e) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, a, e);
      end
   endtask

   task automatic chk_op(input string tag, input int i, input int c, input int ad, input logic [31:0] wd);
      check({tag, " cmd"}, 32'(tr_cmd[i]), 32'(c));
      check({tag, " addr"}, 32'(tr_addr[i]), 32'(ad));
      if (c == 2) check({tag, " data"}, tr_wd[i], wd);
   endtask

   task automatic blank_flash();
      for (int k = 0; k < 128; k++) mem[k] <= '1;
   endtask

   logic [1:0] g_code;
   logic [31:0] g_dout;
   // op: 0 init, 1 read, 2 write
   task automatic do_req(input int op, input logic [31:0] d);
      int t;
      @(negedge clk);
      while (busy) @(negedge clk);
      init_req = (op == 0); rd_req = (op == 1); wr_req = (op == 2); wr_data = d;
      @(negedge clk);
      init_req = 0; rd_req = 0; wr_req = 0;
      t = 0;
      while (!done && t < 5000) begin @(negedge clk); t++; end
      if (!done) check("R10 done timeout", 0, 1);
      g_code = result; g_dout = rd_data;
      @(negedge clk);
      check("R10 done width", 32'(done), 0);
   endtask

   task automatic boot();
      int t;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 busy after reset", 32'(busy), 1);
      t = 0;
      while (busy && t < 5000) begin @(negedge clk); t++; end
   endtask

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] d;
      logic [1:0]  code;
      logic        chk;
      logic [31:0] dout;
   } vec_t;
   localparam vec_t VT [8] = '{
      '{2'd1, 32'h0,         2'd1, 1'b1, 32'h0},          // R5 empty, rd_data kept
      '{2'd2, 32'h1111_1111, 2'd0, 1'b0, 32'h0},          // R3
      '{2'd1, 32'h0,         2'd0, 1'b1, 32'h1111_1111},  // R4
      '{2'd2, 32'hFFFF_FFFF, 2'd0, 1'b0, 32'h0},          // R4 all ones
      '{2'd1, 32'h0,         2'd0, 1'b1, 32'hFFFF_FFFF},
      '{2'd2, 32'h0000_0000, 2'd0, 1'b0, 32'h0},
      '{2'd2, 32'h2222_2222, 2'd0, 1'b0, 32'h0},
      '{2'd1, 32'h0,         2'd0, 1'b1, 32'h2222_2222}
   };

   initial begin
      #(HALF * 2 * 150000);
      n_err++;
      $display("FAIL R10 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int mark;
      blank_flash();
      // R1: request during boot scan is ignored
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 busy after reset", 32'(busy), 1);
      rd_req = 1; @(negedge clk); rd_req = 0;
      begin
         int seen = 0;
         while (busy) begin if (done) seen = 1; @(negedge clk); end
         check("R1 no done while busy", 32'(seen), 0);
      end
      check("R1 boot op count", 32'(tr_n), 5);
      // R6: no valid sector
      mark = tr_n;
      do_req(1, 0); check("R6 read code", 32'(g_code), 2);
      do_req(2, 32'h55); check("R6 write code", 32'(g_code), 2);
      check("R6 no flash op", 32'(tr_n), 32'(mark));
      // R2: init
      mark = tr_n;
      do_req(0, 0); check("R2 init code", 32'(g_code), 0);
      chk_op("R2 op0", mark, 3, 0, 0);
      chk_op("R2 op1", mark + 1, 3, B1, 0);
      chk_op("R2 op2", mark + 2, 2, SG0, 32'h600D);
      // table walk
      foreach (VT[i]) begin
         do_req(int'(VT[i].op), VT[i].d);
         check($sformatf("R3/R4/R5 vec%0d code", i), 32'(g_code), 32'(VT[i].code));
         if (VT[i].chk) check($sformatf("R4/R5 vec%0d data", i), g_dout, VT[i].dout);
      end
      check("R3 slot3", mem[3], 32'h2222_2222);
      check("R3 status word0", mem[ST0], 32'hFFFF_FFF0);
      // fill sector 0 (R11 crosses a status word)
      for (int i = 4; i < S0; i++) begin
         do_req(2, 32'h1000 + i);
         if (i == 32) check("R11 status word1", mem[ST0 + 1], 32'hFFFF_FFFE);
      end
      check("R11 status full w0", mem[ST0], 32'h0);
      check("R11 status full w1", mem[ST0 + 1], 32'hFFFF_FFFC);
      do_req(1, 0); check("R4 last slot", g_dout, 32'h1021);
      // R7: swap order
      mark = tr_n;
      do_req(2, 32'hABCD_0001); check("R7 swap code", 32'(g_code), 0);
      chk_op("R7 read last", mark, 1, 33, 0);
      chk_op("R7 copy", mark + 1, 2, B1, 32'h1021);
      chk_op("R7 new", mark + 2, 2, B1 + 1, 32'hABCD_0001);
      chk_op("R7 status", mark + 3, 2, ST1, 32'hFFFF_FFFC);
      chk_op("R7 sig", mark + 4, 2, SG1, 32'h600D);
      chk_op("R7 erase", mark + 5, 3, 0, 0);
      do_req(1, 0); check("R7 read new sector", g_dout, 32'hABCD_0001);
      check("R7 old sig erased", mem[SG0], 32'hFFFF_FFFF);
      // R8: sector 1 capacity 3
      do_req(2, 32'h5);
      check("R8 slot2 sector1", mem[B1 + 2], 32'h5);
      mark = tr_n;
      do_req(2, 32'h6);
      chk_op("R8 swap back copy", mark + 1, 2, 0, 32'h5);
      chk_op("R8 swap back erase", mark + 5, 3, B1, 0);
      do_req(1, 0); check("R8 read after swap back", g_dout, 32'h6);
      // R9: both sectors signed, sector 1 has fewer sets
      rst_n = 0;
      blank_flash();
      @(negedge clk);
      for (int k = 0; k < 5; k++) mem[k] <= 32'hA0 + k;
      mem[ST0] <= 32'hFFFF_FFE0; mem[SG0] <= 32'h600D;
      mem[B1] <= 32'hB0; mem[B1 + 1] <= 32'hB1; mem[ST1] <= 32'hFFFF_FFFC; mem[SG1] <= 32'h600D;
      mark = tr_n;
      boot();
      chk_op("R9 victim erase", mark + 5, 3, B1, 0);
      check("R9 sector1 sig cleared", mem[SG1], 32'hFFFF_FFFF);
      do_req(1, 0); check("R9 read survivor", g_dout, 32'hA4);
      // only sector 1 valid
      rst_n = 0;
      blank_flash();
      @(negedge clk);
      mem[B1] <= 32'hB0; mem[B1 + 1] <= 32'hB1; mem[ST1] <= 32'hFFFF_FFFC; mem[SG1] <= 32'h600D;
      boot();
      do_req(1, 0); check("R4 read from sector1", g_dout, 32'hB1);
      do_req(2, 32'hB2); check("R3 append sector1", mem[B1 + 2], 32'hB2);
      // R10: write and read together, write wins
      @(negedge clk);
      wr_req = 1; rd_req = 1; wr_data = 32'h77;
      @(negedge clk);
      wr_req = 0; rd_req = 0;
      while (!done) @(negedge clk);
      check("R10 priority code", 32'(result), 0);
      do_req(1, 0); check("R10 write won", g_dout, 32'h77);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule